// File: doc/BRIEF.md
# Voice Interrupt Pending Arbiter

This block keeps two sets of per-voice interrupt flags for a wavetable synthesizer. One set records voices whose sample playback reached its end. The other records voices whose volume ramp finished. Each voice raises a one-cycle set pulse on either source, and the matching flag stays pending until the host collects it.

The host collects interrupts one at a time by writing a dedicated code to the function-select register. Each such write pops exactly one pending voice into a status byte that the host can read back. A wavetable interrupt is always taken before a ramp interrupt, and the lowest voice number wins within a source. On the same cycle the block pulses a clear strobe toward the served voice's control register, so that the register drops its own interrupt flag. Bits 5 and 6 of the combined interrupt status follow whether each vector still holds a pending voice. The interrupt line is high whenever any bit of that combined status is set.

Top module: `voice_irq_arbiter`

## Requirements
- R1: After reset both pending vectors are empty, the status byte reads 0xE8, no clear strobe is active and bits 5 and 6 of the combined status are 0.
- R2: A set pulse on voice v marks v pending from the next cycle. Combined-status bit 5 is 1 exactly while some wavetable voice is pending, and bit 6 is 1 exactly while some ramp voice is pending.
- R3: A pop is a cycle with sel_wr high and sel_code equal to 0x8F. A pop with wavetable voices pending serves the lowest one, v. In that cycle wave_clr carries only bit v; from the next cycle the status byte reads 0x60 | v and v is no longer wave-pending.
- R4: A pop serves a pending wavetable voice even when ramp voices are pending, including a ramp voice with a lower number; ramp_clr stays 0 in that cycle.
- R5: A pop with no wavetable voice pending and ramp voices pending serves the lowest ramp voice, v. In that cycle ramp_clr carries only bit v; from the next cycle the status byte reads 0x80 | v and v is no longer ramp-pending.
- R6: A pop with nothing pending drives no clear strobe and makes the status byte read 0xE8.
- R7: Without a pop (sel_wr low, or any code other than 0x8F), the status byte, both pending vectors and both clear outputs are unchanged or zero; reading the status byte has no effect.
- R8: A set pulse for a voice in the same cycle that a pop clears that voice leaves the voice pending.
- R9: Combined status equals ext_irq with bits 5 and 6 replaced by the two pending summaries; irq_line is 1 exactly when the combined status is nonzero.
- R10: soft_rst empties both pending vectors at the next edge, overriding set pulses in the same cycle, and leaves the status byte unchanged.
- R11: At most one clear strobe bit, over both clear outputs together, is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of both pending vectors |
| wave_set | input | 31 | Per-voice wavetable-end set pulses |
| ramp_set | input | 31 | Per-voice volume-ramp-end set pulses |
| sel_wr | input | 1 | Function-select write strobe |
| sel_code | input | 8 | Function-select write data |
| ext_irq | input | 8 | Interrupt status bits from other sources (bits 5 and 6 ignored) |
| status_byte | output | 8 | Last popped interrupt code |
| wave_clr | output | 31 | Clear strobe toward bit 7 of each voice's wave control register |
| ramp_clr | output | 31 | Clear strobe toward bit 7 of each voice's ramp control register |
| irq_status | output | 8 | Combined interrupt status |
| irq_line | output | 1 | Interrupt request line |

## Verification
A corrupted pending bit cannot be seen until a later pop. It then shows up as a wrong voice number in the status byte one cycle after the pop, or as a wrong bit on a clear strobe in the pop cycle itself. Any pending-summary error appears on irq_status bits 5 and 6 and on irq_line one cycle after the set or pop that caused it. The bench keeps its own copy of both vectors and predicts every strobe and status value. Draining all voices pop by pop exposes hidden state within at most 63 pops.

// File: rtl/varb_pkg.sv
package varb_pkg;
  localparam logic [7:0] SEL_POP_CODE = 8'h8F;
  localparam logic [7:0] ST_NONE      = 8'hE8;
  localparam logic [2:0] TAG_WAVE     = 3'b011;
  localparam logic [2:0] TAG_RAMP     = 3'b100;
  localparam int         IRQ_WAVE_BIT = 5;
  localparam int         IRQ_RAMP_BIT = 6;
  localparam int         VOICE_FIELD  = 5;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WAVE = 2'd1,
    SRC_RAMP = 2'd2
  } src_e;

  // status byte = source tag in [7:5], voice number in [4:0]
  function automatic logic [7:0] status_code(src_e src, logic [VOICE_FIELD-1:0] voice);
    case (src)
      SRC_WAVE: status_code = {TAG_WAVE, voice};
      SRC_RAMP: status_code = {TAG_RAMP, voice};
      default:  status_code = ST_NONE;
    endcase
  endfunction

  // merge pending summaries into the foreign status bits
  function automatic logic [7:0] merge_status(logic [7:0] ext, logic w_any, logic r_any);
    logic [7:0] m;
    m = ext;
    m[IRQ_WAVE_BIT] = w_any;
    m[IRQ_RAMP_BIT] = r_any;
    return m;
  endfunction
endpackage

// File: rtl/varb_pend_vec.sv
module varb_pend_vec #(
  parameter int NV = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic [NV-1:0] set_i,
  input  logic [NV-1:0] clr_i,
  output logic [NV-1:0] pend_o,
  output logic          any_o
);
  logic [NV-1:0] pend_q;
  logic [NV-1:0] pend_d;

  always_comb begin
    if (soft_clr) pend_d = '0;
    else          pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;

  // a new set pulse survives a clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && (set_i != '0)) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (pend_o == '0));
endmodule

// File: rtl/varb_prio_enc.sv
module varb_prio_enc #(
  parameter int NV   = 31,
  parameter int IDXW = 5
) (
  input  logic [NV-1:0]   req,
  output logic [NV-1:0]   grant,
  output logic [IDXW-1:0] idx,
  output logic            valid
);
  logic [NV:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NV; g++) begin : g_chain
      assign grant[g]  = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
    end
  endgenerate

  assign valid = seen[NV];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NV; i++) begin
      if (grant[i]) idx = idx | IDXW'(i);
    end
  end
endmodule

// File: rtl/varb_status_reg.sv
module varb_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] code_i,
  output logic [7:0] status_o
);
  import varb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status_o <= ST_NONE;
    else if (load) status_o <= code_i;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(status_o));
endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter #(
  parameter int NV = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NV-1:0] wave_set,
  input  logic [NV-1:0] ramp_set,
  input  logic          sel_wr,
  input  logic [7:0]    sel_code,
  input  logic [7:0]    ext_irq,
  output logic [7:0]    status_byte,
  output logic [NV-1:0] wave_clr,
  output logic [NV-1:0] ramp_clr,
  output logic [7:0]    irq_status,
  output logic          irq_line
);
  import varb_pkg::*;

  localparam int IDXW = (NV > 1) ? $clog2(NV) : 1;

  logic [NV-1:0]   wave_pend, ramp_pend;
  logic            wave_any, ramp_any;
  logic [NV-1:0]   w_grant, r_grant;
  logic [IDXW-1:0] w_idx, r_idx;
  logic            w_valid, r_valid;
  logic            pop;
  logic            serve_wave, serve_ramp;
  src_e            pop_src;
  logic [VOICE_FIELD-1:0] pop_voice;
  logic [7:0]      pop_code;

  assign pop = sel_wr && (sel_code == SEL_POP_CODE);

  varb_pend_vec #(.NV(NV)) u_wave_pend (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .set_i(wave_set), .clr_i(wave_clr),
    .pend_o(wave_pend), .any_o(wave_any));

  varb_pend_vec #(.NV(NV)) u_ramp_pend (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .set_i(ramp_set), .clr_i(ramp_clr),
    .pend_o(ramp_pend), .any_o(ramp_any));

  varb_prio_enc #(.NV(NV), .IDXW(IDXW)) u_wave_enc (
    .req(wave_pend), .grant(w_grant), .idx(w_idx), .valid(w_valid));

  varb_prio_enc #(.NV(NV), .IDXW(IDXW)) u_ramp_enc (
    .req(ramp_pend), .grant(r_grant), .idx(r_idx), .valid(r_valid));

  // wavetable source has strict precedence
  assign serve_wave = pop && w_valid;
  assign serve_ramp = pop && !w_valid && r_valid;

  assign wave_clr = serve_wave ? w_grant : '0;
  assign ramp_clr = serve_ramp ? r_grant : '0;

  always_comb begin
    if (serve_wave) begin
      pop_src   = SRC_WAVE;
      pop_voice = VOICE_FIELD'(w_idx);
    end else if (serve_ramp) begin
      pop_src   = SRC_RAMP;
      pop_voice = VOICE_FIELD'(r_idx);
    end else begin
      pop_src   = SRC_NONE;
      pop_voice = '0;
    end
  end

  assign pop_code = status_code(pop_src, pop_voice);

  varb_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .load(pop),
    .code_i(pop_code), .status_o(status_byte));

  assign irq_status = merge_status(ext_irq, wave_any, ramp_any);
  assign irq_line   = |irq_status;

  p_single_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({wave_clr, ramp_clr}) <= 1));

  p_wave_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (wave_pend != '0)) |-> (ramp_clr == '0));

  p_wave_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (wave_pend != '0)) |=> (status_byte[7:5] == TAG_WAVE));

  p_ramp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (wave_pend == '0) && (ramp_pend != '0)) |=> (status_byte[7:5] == TAG_RAMP));

  p_none_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (wave_pend == '0) && (ramp_pend == '0)) |=> (status_byte == ST_NONE));

  p_served_gone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_clr != '0) |=> ((wave_pend & $past(wave_clr) & ~$past(wave_set)) == '0));

  p_clr_hits_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_clr != '0) |-> ((ramp_clr & ramp_pend) == ramp_clr));

  p_no_pop_no_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |-> ((wave_clr == '0) && (ramp_clr == '0)));
endmodule

// File: tb/tb_voice_irq_arbiter.sv
module tb_voice_irq_arbiter;
  localparam int NV = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [NV-1:0] wave_set = '0;
  logic [NV-1:0] ramp_set = '0;
  logic          sel_wr = 1'b0;
  logic [7:0]    sel_code = 8'h00;
  logic [7:0]    ext_irq = 8'h00;
  logic [7:0]    status_byte;
  logic [NV-1:0] wave_clr, ramp_clr;
  logic [7:0]    irq_status;
  logic          irq_line;

  int checks = 0;
  int errors = 0;
  logic [NV-1:0] m_w = '0, m_r = '0;
  logic [7:0]    m_st = 8'hE8;
  logic [31:0]   lf = 32'h1234_5678;

  always #2 clk = ~clk;

  voice_irq_arbiter #(.NV(NV)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wave_set(wave_set), .ramp_set(ramp_set),
    .sel_wr(sel_wr), .sel_code(sel_code), .ext_irq(ext_irq),
    .status_byte(status_byte), .wave_clr(wave_clr), .ramp_clr(ramp_clr),
    .irq_status(irq_status), .irq_line(irq_line));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [NV-1:0] v);
    for (int i = 0; i < NV; i++) if (v[i]) return i;
    return -1;
  endfunction

  // one cycle: drive at negedge, check strobes, clock, then check registered view
  task automatic step(input logic [NV-1:0] ws, input logic [NV-1:0] rs,
                      input logic wr, input logic [7:0] code,
                      input logic srst, input logic [7:0] ext);
    logic [NV-1:0] ew, er;
    logic [7:0]    ex;
    string tag;
    int lw, lr;
    @(negedge clk);
    wave_set = ws; ramp_set = rs; sel_wr = wr; sel_code = code;
    soft_rst = srst; ext_irq = ext;
    #1;
    ew = '0; er = '0;
    lw = lowest(m_w); lr = lowest(m_r);
    tag = "R7";
    if (wr && code == 8'h8F) begin
      if (lw >= 0) begin
        ew[lw] = 1'b1; m_st = 8'h60 | 8'(lw);
        tag = (lr >= 0) ? "R4" : "R3";
      end else if (lr >= 0) begin
        er[lr] = 1'b1; m_st = 8'h80 | 8'(lr); tag = "R5";
      end else begin
        m_st = 8'hE8; tag = "R6";
      end
    end
    chk({tag, " wave_clr"}, 32'(wave_clr), 32'(ew));
    chk({tag, " ramp_clr"}, 32'(ramp_clr), 32'(er));
    chk("R11 strobe count", 32'($countones({wave_clr, ramp_clr}) <= 1), 32'd1);
    if (srst) begin m_w = '0; m_r = '0; end
    else begin
      m_w = (m_w & ~ew) | ws;
      m_r = (m_r & ~er) | rs;
    end
    @(posedge clk); #1;
    chk({tag, " status"}, 32'(status_byte), 32'(m_st));
    ex = ext; ex[5] = |m_w; ex[6] = |m_r;
    chk("R2 R9 irq_status", 32'(irq_status), 32'(ex));
    chk("R9 irq_line", 32'(irq_line), 32'(ex != 8'h00));
  endtask

  task automatic idle();
    step('0, '0, 1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic pop();
    step('0, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 status", 32'(status_byte), 32'h0000_00E8);
    chk("R1 wave_clr", 32'(wave_clr), 32'd0);
    chk("R1 ramp_clr", 32'(ramp_clr), 32'd0);
    chk("R1 irq_status", 32'(irq_status), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // per-voice sweep: wave beats ramp on the same voice, then ramp, then none
    for (int v = 0; v < NV; v++) begin
      step(NV'(1) << v, NV'(1) << v, 1'b0, 8'h00, 1'b0, 8'h00);
      chk("R2 wave bit", 32'(irq_status[5]), 32'd1);
      pop();
      pop();
      pop();
      chk("R6 none", 32'(status_byte), 32'h0000_00E8);
    end

    // R4: lower ramp voice still loses to a higher wave voice
    step(NV'(1) << 20, NV'(1) << 2, 1'b0, 8'h00, 1'b0, 8'h00);
    pop();
    chk("R4 wave over lower ramp", 32'(status_byte), 32'h0000_0074);
    pop();
    chk("R5 ramp after", 32'(status_byte), 32'h0000_0082);

    // R3: several wave voices drain lowest first
    step(NV'(1) << 30 | NV'(1) << 7 | NV'(1) << 12, '0, 1'b0, 8'h00, 1'b0, 8'h00);
    pop(); chk("R3 first", 32'(status_byte), 32'h0000_0067);
    pop(); chk("R3 second", 32'(status_byte), 32'h0000_006C);
    pop(); chk("R3 third", 32'(status_byte), 32'h0000_007E);

    // R8: set in the pop cycle of the same voice keeps it pending
    step(NV'(1) << 3, '0, 1'b0, 8'h00, 1'b0, 8'h00);
    step(NV'(1) << 3, '0, 1'b1, 8'h8F, 1'b0, 8'h00);
    chk("R8 served", 32'(status_byte), 32'h0000_0063);
    chk("R8 still pending", 32'(irq_status[5]), 32'd1);
    pop(); chk("R8 served again", 32'(status_byte), 32'h0000_0063);

    // R7: other codes or no strobe change nothing
    step('0, NV'(1) << 9, 1'b0, 8'h00, 1'b0, 8'h00);
    step('0, '0, 1'b1, 8'h8E, 1'b0, 8'h00);
    step('0, '0, 1'b0, 8'h8F, 1'b0, 8'h00);
    chk("R7 status held", 32'(status_byte), 32'h0000_0063);
    pop(); chk("R7 ramp still there", 32'(status_byte), 32'h0000_0089);

    // R10: soft reset wins over same-cycle set and keeps status
    step(NV'(1) << 4, NV'(1) << 5, 1'b0, 8'h00, 1'b0, 8'h00);
    step(NV'(1) << 6, '0, 1'b0, 8'h00, 1'b1, 8'h00);
    chk("R10 status kept", 32'(status_byte), 32'h0000_0089);
    chk("R10 summaries", 32'(irq_status & 8'h60), 32'd0);
    pop(); chk("R10 nothing left", 32'(status_byte), 32'h0000_00E8);

    // R9: foreign bits pass, foreign 5/6 ignored
    step('0, '0, 1'b0, 8'h00, 1'b0, 8'h61);
    chk("R9 mask", 32'(irq_status), 32'h0000_0001);
    step('0, '0, 1'b0, 8'h00, 1'b0, 8'h60);
    chk("R9 line low", 32'(irq_line), 32'd0);

    // pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      logic [NV-1:0] ws, rs;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ws = (lf[4:0] != 5'd31 && lf[5] && lf[6]) ? (NV'(1) << lf[4:0]) : '0;
      rs = (lf[11:7] != 5'd31 && lf[12] && lf[13]) ? (NV'(1) << lf[11:7]) : '0;
      step(ws, rs, lf[14] | lf[15], lf[16] ? 8'h8F : {4'h8, lf[20:17]},
           (lf[27:22] == 6'd0), {lf[31:28], lf[3:0]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule